// File: doc/BRIEF.md
# Cartridge Read-Strobe to SDRAM Read Bridge

This block sits between a cartridge slot and a single-command SDRAM controller, all inside one fast system clock domain (nominally 48 MHz). The slot's active-low output-enable strobe arrives asynchronously. The block synchronises it and turns each genuine cartridge read into exactly one single-cycle read request. The request carries the word address, which is the byte address with bit 0 dropped. When the controller returns the 16-bit word, the block holds it and presents it to the cartridge data bus. The bus is driven only while the strobe stays asserted. The tri-state is modelled as a separate enable output.

The controller accepts a command on one clock and then stays busy for about 12 cycles. A read that begins while it is busy is kept pending and is issued on the first ready cycle. The rising edge of the strobe at the end of a read can be slow and noisy. For that reason, the strobe level is ignored for a fixed lockout window after the first sign of deassertion, so a bounce cannot start a phantom second read. A counter of issued requests is exposed on the ports.

The controller is a finite-state machine with these states:
- ST_IDLE: waiting for a read.
- ST_PEND: a read has been seen and the controller is still busy.
- ST_WAIT: the request has been issued and the data has not yet returned.
- ST_HOLD: the data is held and driven on the bus.
- ST_LOCK: the lockout window is running.

Transitions:
- IDLE to WAIT: the strobe is low and the controller is ready. The request is issued on this cycle.
- IDLE to PEND: the strobe is low and the controller is busy.
- PEND to WAIT: the controller becomes ready. The request is issued on this cycle.
- WAIT to HOLD: the read data is valid.
- WAIT to LOCK: the strobe rises before the data returns.
- HOLD to LOCK: the strobe rises.
- LOCK to IDLE: the window has expired.

Top module: `cart_read_bridge`

## Requirements
- R1: During and directly after reset, `sd_req` is 0, `sd_cmd` is 0 (no-op), `cart_data_oe` is 0 and `req_count` is 0.
- R2: The strobe passes through a two-flop synchroniser. A request is issued in the first cycle in which the synchronised strobe is seen low while the block is idle and the controller is not busy. A low level on `cart_oe_n` sampled at clock edge k can therefore produce `sd_req` in the cycle after edge k+1.
- R3: A request is a one-cycle `sd_req` pulse. During that pulse `sd_cmd` is 2'b01 (read) and `sd_addr` equals `cart_addr[23:1]`. In every other cycle `sd_cmd` is 2'b00. Cartridge reads are at even byte addresses.
- R4: Each genuine read, in which the strobe goes low and later high, produces exactly one request. This holds even when the rising edge bounces.
- R5: Once the synchronised strobe is first seen high after a read, its level is ignored for LOCKOUT_CYC cycles (default 5). Lows that fall wholly inside the window start no read.
- R6: No request is issued while `sd_busy` is 1. A read seen while the controller is busy is held pending and issued in the first cycle `sd_busy` is 0. It is never dropped and never duplicated.
- R7: The word on `sd_rdata` is captured when `sd_rvalid` is 1 and the read is still open. It is driven on `cart_data` with `cart_data_oe` set only while the synchronised strobe stays low. The value stays stable while it is driven.
- R8: If the strobe rises before the data returns, the bus is never enabled for that read, and the late data is ignored.
- R9: `req_count` increments by one on every request and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cart_oe_n | input | 1 | Asynchronous active-low cartridge output-enable strobe |
| cart_addr | input | ADDR_W | Cartridge byte address |
| cart_data | output | DATA_W | Word presented to the cartridge bus |
| cart_data_oe | output | 1 | Bus drive enable (tri-state control) |
| sd_req | output | 1 | Single-cycle command strobe to the SDRAM controller |
| sd_cmd | output | 2 | Command code: 2'b01 read, 2'b00 no-op |
| sd_addr | output | ADDR_W-1 | Word address of the request |
| sd_busy | input | 1 | Controller cannot accept a command |
| sd_rvalid | input | 1 | Read data valid pulse from the controller |
| sd_rdata | input | DATA_W | Read data from the controller |
| req_count | output | CNT_W | Number of requests issued, wrapping |

## Verification
The bench builds the bridge with LOCKOUT_CYC=4 and CNT_W=4. The narrow counter makes a wrap reachable within a couple of dozen reads. The short window lets a bounce pattern of two extra lows fall entirely inside it. A controller model, busy for 12 cycles with data returned 6 cycles after each request, brings within reach the pending path after back-to-back reads, a strobe that ends before the data returns, and an extra busy phase forced by the bench.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PEND = 3'd1,
        ST_WAIT = 3'd2,
        ST_HOLD = 3'd3,
        ST_LOCK = 3'd4
    } crb_state_e;

    typedef enum logic [1:0] {
        SDC_NOP  = 2'b00,
        SDC_READ = 2'b01
    } sdc_cmd_e;

endpackage

// File: rtl/crb_sync.sv
module crb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic level_low
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign level_low = ~chain_q[STAGES-1];

endmodule

// File: rtl/crb_lockout.sv
module crb_lockout #(
    parameter int CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (done)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R5: the window counter never runs past its last cycle
    assert_lock_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5: a running window advances by exactly one per cycle until done
    assert_lock_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (cnt_q == $past(cnt_q) + 1'b1) || !run);

endmodule

// File: rtl/crb_fsm.sv
module crb_fsm
    import crb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_low,
    input  logic lock_done,
    input  logic sd_busy,
    input  logic sd_rvalid,
    output logic issue,
    output logic lock_run,
    output logic capture,
    output logic drive
);
    crb_state_e state_q;
    crb_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_low) state_d = sd_busy ? ST_PEND : ST_WAIT;
            end
            ST_PEND: begin
                if (!sd_busy) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!strobe_low)    state_d = ST_LOCK;
                else if (sd_rvalid) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!strobe_low) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (lock_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        issue    = 1'b0;
        lock_run = 1'b0;
        capture  = 1'b0;
        drive    = 1'b0;
        unique case (state_q)
            ST_IDLE: issue    = strobe_low && !sd_busy;
            ST_PEND: issue    = !sd_busy;
            ST_WAIT: capture  = strobe_low && sd_rvalid;
            ST_HOLD: drive    = strobe_low;
            ST_LOCK: lock_run = 1'b1;
            default: ;
        endcase
    end

    // R5: strobe level has no effect until the window expires
    assert_lock_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !lock_done) |=> state_q == ST_LOCK);

    // R6: a pending read waits for the controller and is not dropped
    assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && sd_busy) |=> state_q == ST_PEND);

    // R4: after issuing, no second request before the read is closed
    assert_one_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (state_q == ST_WAIT));

endmodule

// File: rtl/crb_reqcount.sv
module crb_reqcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count_q <= '0;
        else if (inc) count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    // R9: one step per request, wrapping
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == $past(count) + 1'b1);

    // R9: no change without a request
    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

endmodule

// File: rtl/cart_read_bridge.sv
module cart_read_bridge
    import crb_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int LOCKOUT_CYC = 5,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cart_oe_n,
    input  logic [ADDR_W-1:0] cart_addr,
    output logic [DATA_W-1:0] cart_data,
    output logic              cart_data_oe,
    output logic              sd_req,
    output logic [1:0]        sd_cmd,
    output logic [ADDR_W-2:0] sd_addr,
    input  logic              sd_busy,
    input  logic              sd_rvalid,
    input  logic [DATA_W-1:0] sd_rdata,
    output logic [CNT_W-1:0]  req_count
);
    logic strobe_low;
    logic lock_run;
    logic lock_done;
    logic issue;
    logic capture;
    logic drive;
    logic [DATA_W-1:0] word_q;

    crb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_n   (cart_oe_n),
        .level_low (strobe_low)
    );

    crb_lockout #(.CYCLES(LOCKOUT_CYC)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (lock_run),
        .done  (lock_done)
    );

    crb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_low (strobe_low),
        .lock_done  (lock_done),
        .sd_busy    (sd_busy),
        .sd_rvalid  (sd_rvalid),
        .issue      (issue),
        .lock_run   (lock_run),
        .capture    (capture),
        .drive      (drive)
    );

    crb_reqcount #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (issue),
        .count (req_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= sd_rdata;
    end

    assign sd_req       = issue;
    assign sd_cmd       = issue ? SDC_READ : SDC_NOP;
    assign sd_addr      = cart_addr[ADDR_W-1:1];
    assign cart_data    = word_q;
    assign cart_data_oe = drive;

    // R6: never command a busy controller
    assert_req_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sd_req |-> !sd_busy);

    // R3: a request lasts one cycle
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sd_req |=> !sd_req);

    // R3: reads are word aligned
    assert_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sd_req |-> !cart_addr[0]);

    // R7: the driven word does not change under the cartridge
    assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_data_oe && $past(cart_data_oe)) |-> $stable(cart_data));

    // R8: the bus is only enabled once the strobe is seen low
    assert_oe_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cart_data_oe) |-> $past(strobe_low));

endmodule

// File: tb/tb_cart_read_bridge.sv
`timescale 1ns/100ps
module tb_cart_read_bridge;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int LK = 4;
    localparam int CW = 4;
    localparam int BUSY_LEN = 12;
    localparam int RD_LAT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cart_oe_n = 1'b1;
    logic [AW-1:0] cart_addr = '0;
    logic [DW-1:0] cart_data;
    logic cart_data_oe;
    logic sd_req;
    logic [1:0] sd_cmd;
    logic [AW-2:0] sd_addr;
    logic sd_busy = 1'b0;
    logic sd_rvalid = 1'b0;
    logic [DW-1:0] sd_rdata = '0;
    logic [CW-1:0] req_count;

    always #2.5 clk = ~clk;

    cart_read_bridge #(.ADDR_W(AW), .DATA_W(DW), .LOCKOUT_CYC(LK),
                       .SYNC_STAGES(2), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cart_oe_n(cart_oe_n), .cart_addr(cart_addr),
        .cart_data(cart_data), .cart_data_oe(cart_data_oe), .sd_req(sd_req),
        .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_busy(sd_busy),
        .sd_rvalid(sd_rvalid), .sd_rdata(sd_rdata), .req_count(req_count)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // controller model
    bit ext_busy = 0;
    bit req_seen = 0;
    logic [AW-2:0] addr_seen = '0;
    int ctl_cnt = 0;
    logic [AW-2:0] ctl_addr = '0;

    always @(posedge clk) begin
        #1;
        if (!rst_n) ctl_cnt = 0;
        else if (req_seen) begin ctl_cnt = 1; ctl_addr = addr_seen; end
        else if (ctl_cnt != 0 && ctl_cnt < BUSY_LEN) ctl_cnt++;
        else ctl_cnt = 0;
        sd_busy   = (ctl_cnt != 0) || ext_busy;
        sd_rvalid = (ctl_cnt == RD_LAT);
        sd_rdata  = ctl_addr[15:0] ^ 16'hA55A;
    end

    // reference model: phases 0 idle, 1 waiting for ready, 2 awaiting data, 3 holding, 4 lockout
    bit m_p1, m_p2;
    int m_phase, m_lk;
    logic [DW-1:0] m_data;
    int m_cnt;
    int oe_hi;

    always @(negedge clk) begin
        bit low, ereq, eoe;
        if (!rst_n) begin
            m_p1 = 1; m_p2 = 1; m_phase = 0; m_lk = 0; m_data = '0; m_cnt = 0;
            req_seen = 0;
        end else begin
            low  = !m_p2;
            ereq = (m_phase == 0 && low && !sd_busy) || (m_phase == 1 && !sd_busy);
            eoe  = (m_phase == 3) && low;
            check(sd_req === ereq, "R2 request timing", sd_req, ereq);
            if (ereq) begin
                check(sd_cmd === 2'b01, "R3 read code", sd_cmd, 2'b01);
                check(sd_addr === cart_addr[AW-1:1], "R3 word address", sd_addr, cart_addr[AW-1:1]);
            end else begin
                check(sd_cmd === 2'b00, "R3 idle code", sd_cmd, 0);
            end
            if (sd_req && sd_busy) check(0, "R6 request while busy", 1, 0);
            check(cart_data_oe === eoe, "R7 drive enable", cart_data_oe, eoe);
            if (eoe) check(cart_data === m_data, "R7 driven word", cart_data, m_data);
            check(req_count === CW'(m_cnt), "R9 request count", req_count, CW'(m_cnt));
            if (cart_data_oe) oe_hi++;
            case (m_phase)
                0: if (low) begin
                       if (sd_busy) m_phase = 1;
                       else begin m_phase = 2; m_cnt = (m_cnt + 1) % (1 << CW); end
                   end
                1: if (!sd_busy) begin m_phase = 2; m_cnt = (m_cnt + 1) % (1 << CW); end
                2: if (!low) begin m_phase = 4; m_lk = 0; end
                   else if (sd_rvalid) begin m_phase = 3; m_data = sd_rdata; end
                3: if (!low) begin m_phase = 4; m_lk = 0; end
                default: begin
                    m_lk++;
                    if (m_lk == LK) m_phase = 0;
                end
            endcase
            m_p2 = m_p1;
            m_p1 = cart_oe_n;
            req_seen  = sd_req;
            addr_seen = sd_addr;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    int reads = 0;

    task automatic do_read(input logic [AW-1:0] a, input int low_len, input bit bounce, input int gap);
        cart_addr = a;
        cart_oe_n = 1'b0;
        reads++;
        repeat (low_len) step();
        cart_oe_n = 1'b1;
        if (bounce) begin
            step(); cart_oe_n = 1'b0;
            step(); cart_oe_n = 1'b1;
            step(); cart_oe_n = 1'b0;
            step(); cart_oe_n = 1'b1;
        end
        repeat (gap) step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int c0, o0;
        repeat (4) step();
        check(sd_req === 1'b0, "R1 reset request", sd_req, 0);
        check(sd_cmd === 2'b00, "R1 reset code", sd_cmd, 0);
        check(cart_data_oe === 1'b0, "R1 reset drive", cart_data_oe, 0);
        check(req_count === '0, "R1 reset count", req_count, 0);
        rst_n = 1'b1;
        repeat (3) step();
        check(req_count === '0, "R1 count after reset", req_count, 0);

        // plain read held until data is driven
        o0 = oe_hi;
        do_read(24'h000206, 16, 0, 20);
        check(req_count === CW'(1), "R4 one request per read", req_count, 1);
        check(oe_hi > o0, "R7 bus driven during read", oe_hi - o0, 1);

        // bouncing rising edge
        c0 = int'(req_count);
        do_read(24'h000208, 16, 1, 20);
        check(int'(req_count) === (c0 + 1) % 16, "R5 bounce ignored", req_count, (c0 + 1) % 16);

        // strobe ends before data returns
        o0 = oe_hi;
        do_read(24'hA10008, 3, 0, 20);
        check(oe_hi == o0, "R8 no drive on early end", oe_hi - o0, 0);

        // controller busy at strobe assertion
        c0 = int'(req_count);
        ext_busy = 1;
        cart_addr = 24'h00FDFE;
        cart_oe_n = 1'b0;
        reads++;
        repeat (6) step();
        check(sd_req === 1'b0, "R6 held while busy", sd_req, 0);
        ext_busy = 0;
        repeat (14) step();
        cart_oe_n = 1'b1;
        repeat (20) step();
        check(int'(req_count) === (c0 + 1) % 16, "R6 pending issued once", req_count, (c0 + 1) % 16);

        // back-to-back reads into a still busy controller
        c0 = int'(req_count);
        do_read(24'h00020A, 3, 0, LK + 2);
        do_read(24'h00020C, 16, 0, 20);
        check(int'(req_count) === (c0 + 2) % 16, "R6 back-to-back pending", req_count, (c0 + 2) % 16);

        // long run for counter wrap
        for (int i = 0; i < 18; i++) begin
            do_read(24'h010000 + AW'(i * 2), 16, i[0], 10);
        end
        check(int'(req_count) === reads % 16, "R9 count wraps", req_count, reads % 16);
        check(int'(req_count) === reads % 16, "R4 requests equal reads", req_count, reads % 16);
        finish_run();
    end
endmodule